// File: doc/BRIEF.md
# Bit-Serial Adder-Subtractor

This block adds or subtracts two `WIDTH`-bit operands one bit per clock. It uses one full adder and one carry flip-flop. A one-cycle `start` pulse loads both operands into their own shift registers, samples the `sub` mode input and presets the carry flip-flop. The carry is set to 0 for an add and to 1 for a subtract. Then exactly `WIDTH` shift cycles follow. In each one, the least-significant remaining bit of each operand is taken from bit 0 of its register. The B bit is XOR-ed with the mode, so it is inverted when subtracting. The adder's sum bit is shifted into the top of a result register.

After the last shift cycle the result register holds the answer with its least-significant bit in bit 0. The carry flip-flop holds the final carry, a signed-overflow flag is valid, and `done` is raised for one cycle. The outputs then hold until the next accepted start. A subtraction is computed as A plus the two's complement of B. No correction is applied for unsigned A < B, so the result is then the two's complement of B − A.

Top module: `serial_addsub`

## Requirements
- R1: A synchronous active-high `rst` clears `result`, `carry_out`, `overflow` and `done` to 0 and abandons any operation in progress, so no `done` follows it.
- R2: A `start` seen high on a rising edge while idle begins an operation. Exactly `WIDTH` shift cycles follow, and `done` is 1 for exactly one cycle, on the cycle after the `WIDTH`+1-th rising edge counted from the start edge.
- R3: With `sub`=0 at the start edge, at `done` `result` equals (A + B) mod 2^WIDTH and `carry_out` equals bit `WIDTH` of the full sum A + B.
- R4: With `sub`=1 at the start edge, at `done` `result` equals (A + ~B + 1) mod 2^WIDTH, and `carry_out` is 1 exactly when A >= B as unsigned numbers.
- R5: A subtraction with unsigned A < B gives `result` = 2^WIDTH − (B − A), the two's complement of B − A, with no correction and `carry_out` = 0.
- R6: At `done`, `overflow` equals the carry into the most-significant bit position XOR the carry out of it. This is 1 exactly when the two's-complement signed result does not fit in `WIDTH` bits.
- R7: A `start` pulse that arrives while an operation is running is ignored: it neither restarts the operation, nor changes its result, nor produces an extra `done`.
- R8: After `done`, `result`, `carry_out` and `overflow` keep their values until the next accepted start, whatever `a_in`, `b_in` and `sub` do.
- R9: The mode is sampled only at the start edge; changing `sub` during the shift cycles does not change the operation performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that loads operands and begins an operation when idle |
| sub | input | 1 | Mode: 0 adds, 1 subtracts (sampled at start) |
| a_in | input | WIDTH | Parallel operand A |
| b_in | input | WIDTH | Parallel operand B |
| result | output | WIDTH | Result register, LSB in bit 0 once complete |
| carry_out | output | 1 | Final carry flip-flop value |
| overflow | output | 1 | Signed-overflow flag of the last operation |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench runs every pair of 4-bit operands in both modes, back to back. This covers carries that ripple through every bit, pairs that overflow in the signed sense, and both sides of the unsigned A >= B boundary. That boundary is what tells a correct carry preset apart from a missing or inverted one. It also separates an inverted B bit from a plain one. Separate sequences cover three more cases. A second start and a mode flip are sent in the middle of a run, which shows whether the running operation is protected. The operand inputs are changed after completion, which shows whether the outputs hold. A reset is applied mid-operation, which must leave no stray completion.

// File: rtl/serial_addsub_pkg.sv
package serial_addsub_pkg;

    localparam int DEF_WIDTH = 4;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic sum;
        logic cout;
    } fa_out_t;

    // Conditional inversion of the serial B bit.
    function automatic logic mode_bit(input logic y, input logic inv);
        return y ^ inv;
    endfunction

    // One-bit full adder.
    function automatic fa_out_t full_add(input logic x, input logic y, input logic c);
        fa_out_t r;
        r.sum  = x ^ y ^ c;
        r.cout = (x & y) | (c & (x ^ y));
        return r;
    endfunction

endpackage

// File: rtl/sas_shift_reg.sv
module sas_shift_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] par_in,
    input  logic         ser_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= par_in;
        end else if (shift) begin
            q <= {ser_in, q[W-1:1]};
        end
    end
endmodule

// File: rtl/sas_bit_slice.sv
module sas_bit_slice
    import serial_addsub_pkg::*;
(
    input  logic x,
    input  logic y,
    input  logic inv,
    input  logic cin,
    output logic sum,
    output logic cout
);
    fa_out_t r;

    always_comb begin
        r    = full_add(x, mode_bit(y, inv), cin);
        sum  = r.sum;
        cout = r.cout;
    end
endmodule

// File: rtl/sas_sequencer.sv
module sas_sequencer
    import serial_addsub_pkg::*;
#(
    parameter int W  = 4,
    parameter int CW = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          load,
    output logic          shift,
    output logic          last,
    output logic          run,
    output logic [CW-1:0] cnt,
    output logic          done
);
    localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

    seq_state_e state_q;
    logic [CW-1:0] cnt_q;
    logic done_q;

    always_comb begin
        load  = start && (state_q == SEQ_IDLE);
        shift = (state_q == SEQ_RUN);
        last  = shift && (cnt_q == LAST_CNT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= last;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (load) begin
                        state_q <= SEQ_RUN;
                        cnt_q   <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (last) begin
                        state_q <= SEQ_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign run  = (state_q == SEQ_RUN);
    assign cnt  = cnt_q;
    assign done = done_q;
endmodule

// File: rtl/serial_addsub.sv
module serial_addsub
    import serial_addsub_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             sub,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             overflow,
    output logic             done
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam int NOPS = 2;

    logic          seq_load, seq_shift, seq_last, seq_run;
    logic [CW-1:0] seq_cnt;
    logic          mode_q, carry_q, ovf_q;
    logic          sum_bit, cout_bit;

    logic [WIDTH-1:0] op_par [NOPS];
    logic [WIDTH-1:0] op_q   [NOPS];
    logic [WIDTH-1:0] res_q;

    sas_sequencer #(.W(WIDTH), .CW(CW)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (seq_load),
        .shift (seq_shift),
        .last  (seq_last),
        .run   (seq_run),
        .cnt   (seq_cnt),
        .done  (done)
    );

    assign op_par[0] = a_in;
    assign op_par[1] = b_in;

    // Operand shift registers, consumed LSB first from bit 0.
    for (genvar g = 0; g < NOPS; g++) begin : g_op
        sas_shift_reg #(.W(WIDTH)) u_op (
            .clk    (clk),
            .rst    (rst),
            .load   (seq_load),
            .shift  (seq_shift),
            .par_in (op_par[g]),
            .ser_in (1'b0),
            .q      (op_q[g])
        );
    end

    logic [2*WIDTH-3:0] unused_op_bits;
    assign unused_op_bits = {op_q[0][WIDTH-1:1], op_q[1][WIDTH-1:1]};

    sas_bit_slice u_slice (
        .x    (op_q[0][0]),
        .y    (op_q[1][0]),
        .inv  (mode_q),
        .cin  (carry_q),
        .sum  (sum_bit),
        .cout (cout_bit)
    );

    // Result register: sum bits enter at the top.
    sas_shift_reg #(.W(WIDTH)) u_res (
        .clk    (clk),
        .rst    (rst),
        .load   (seq_load),
        .shift  (seq_shift),
        .par_in ('0),
        .ser_in (sum_bit),
        .q      (res_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= 1'b0;
            carry_q <= 1'b0;
            ovf_q   <= 1'b0;
        end else if (seq_load) begin
            mode_q  <= sub;
            carry_q <= sub;
            ovf_q   <= 1'b0;
        end else if (seq_shift) begin
            carry_q <= cout_bit;
            if (seq_last) begin
                ovf_q <= carry_q ^ cout_bit;
            end
        end
    end

    assign result    = res_q;
    assign carry_out = carry_q;
    assign overflow  = ovf_q;
endmodule

// File: rtl/serial_addsub_chk.sv
module serial_addsub_chk #(
    parameter int W  = 4,
    parameter int CW = (W > 1) ? $clog2(W) : 1
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          sub,
    input logic          run,
    input logic [CW-1:0] cnt,
    input logic          done,
    input logic [W-1:0]  result,
    input logic          carry
);
    localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

    // R2: done lasts exactly one cycle
    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: last shift cycle is followed by done and idle
    a_r2_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (run && cnt == LAST_CNT) |=> (done && !run));

    // R2: shift counter advances by one per running cycle
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        (run && cnt != LAST_CNT) |=> (cnt == $past(cnt) + 1'b1));

    // R7: a running operation is not cut short by start
    a_r7_run_holds: assert property (@(posedge clk) disable iff (rst)
        (run && cnt != LAST_CNT) |=> run);

    // R4: carry flip-flop preset to the mode at an accepted start
    a_r4_carry_preset: assert property (@(posedge clk) disable iff (rst)
        ($past(start) && !$past(run) && !$past(rst)) |-> (carry == $past(sub) && run));

    // R8: result holds while idle and no start arrives
    a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(run) && !$past(start)) |-> $stable(result));
endmodule

bind serial_addsub serial_addsub_chk #(.W(WIDTH), .CW(CW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .sub    (sub),
    .run    (seq_run),
    .cnt    (seq_cnt),
    .done   (done),
    .result (result),
    .carry  (carry_out)
);

// File: tb/test_serial_addsub.sv
module test_serial_addsub;
    localparam int W = 4;
    localparam int MAXV = 1 << W;

    typedef struct {
        logic [W-1:0] res;
        logic         co;
        logic         ov;
        int           due;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         sub = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] result;
    logic         carry_out, overflow, done;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    logic prev_done = 1'b0;
    exp_t exp_q[$];

    serial_addsub #(.WIDTH(W)) i_serial_addsub (
        .clk(clk), .rst(rst), .start(start), .sub(sub),
        .a_in(a_in), .b_in(b_in), .result(result),
        .carry_out(carry_out), .overflow(overflow), .done(done)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int sval(input logic [W-1:0] v);
        return v[W-1] ? int'(v) - MAXV : int'(v);
    endfunction

    function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic s);
        exp_t e;
        logic [W:0] full;
        int sr;
        full  = {1'b0, a} + {1'b0, (s ? ~b : b)} + {{W{1'b0}}, s};
        e.res = full[W-1:0];
        e.co  = full[W];
        sr    = s ? sval(a) - sval(b) : sval(a) + sval(b);
        e.ov  = (sr > MAXV/2 - 1) || (sr < -(MAXV/2));
        e.tag = !s ? "R3" : ((a < b) ? "R5" : "R4");
        e.due = 0;
        return e;
    endfunction

    // Driver: called at a negedge; returns at the negedge where done is due.
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
        exp_t e;
        e = model(a, b, s);
        e.due = cyc + 1 + W;
        exp_q.push_back(e);
        a_in = a; b_in = b; sub = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (W) @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst) begin
            prev_done <= 1'b0;
        end else begin
            if (prev_done && done)
                chk(1'b0, "R2", "done wider than one cycle", 1, 0);
            if (done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1/R7", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(result == e.res, e.tag, "result", int'(result), int'(e.res));
                    chk(carry_out == e.co, e.tag, "carry_out", int'(carry_out), int'(e.co));
                    chk(overflow == e.ov, "R6", "overflow", int'(overflow), int'(e.ov));
                    chk(cyc == e.due, "R2", "done timing", cyc, e.due);
                end
            end
            prev_done <= done;
        end
    end

    initial begin
        logic [W-1:0] held_r;
        logic held_c, held_o;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(result == '0 && carry_out == 1'b0 && overflow == 1'b0 && done == 1'b0,
            "R1", "reset outputs", int'({result, carry_out, overflow, done}), 0);

        // R3 R4 R5 R6: exhaustive, back to back
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < MAXV; a++)
                for (int b = 0; b < MAXV; b++)
                    run_op(W'(a), W'(b), s[0]);
        @(negedge clk);

        // R7 R9: second start and mode flip during a run (5 + 3 add = 8)
        begin
            exp_t e;
            e = model(4'd5, 4'd3, 1'b0);
            e.due = cyc + 1 + W;
            exp_q.push_back(e);
            a_in = 4'd5; b_in = 4'd3; sub = 1'b0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            a_in = 4'd15; b_in = 4'd15; sub = 1'b1; start = 1'b1;  // ignored (R7)
            @(negedge clk);
            start = 1'b0;                                       // sub stays 1 (R9)
            repeat (W - 2) @(negedge clk);
        end
        chk(done == 1'b1 && result == 4'd8, "R9", "mode sampled at start only",
            int'(result), 8);
        repeat (W + 2) @(negedge clk);
        chk(exp_q.size() == 0 && done == 1'b0, "R7", "no extra done from ignored start",
            exp_q.size(), 0);

        // R8: hold after done while inputs wander
        run_op(4'd9, 4'd4, 1'b1);
        held_r = result; held_c = carry_out; held_o = overflow;
        a_in = 4'd1; b_in = 4'd14; sub = 1'b0;
        repeat (4) @(negedge clk);
        a_in = 4'd7; sub = 1'b1;
        repeat (3) @(negedge clk);
        chk(result == held_r, "R8", "result held", int'(result), int'(held_r));
        chk(carry_out == held_c && overflow == held_o, "R8", "flags held",
            int'({carry_out, overflow}), int'({held_c, held_o}));

        // R1: reset mid-operation
        a_in = 4'd6; b_in = 4'd7; sub = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(result == '0 && carry_out == 1'b0 && overflow == 1'b0 && done == 1'b0,
            "R1", "mid-run reset clears", int'({result, carry_out, overflow, done}), 0);
        repeat (W + 3) @(negedge clk);
        chk(exp_q.size() == 0, "R1", "no pending results", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cyc > 20000);
        checks++;
        failures++;
        $display("FAIL R2 watchdog expired: actual=%0d expected=%0d", cyc, 20000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule